// File: doc/BRIEF.md
# Multi-Beat Bus Transfer Master

This block is a bus master for a single AHB-Lite subordinate. A host asks for one access with a start address, a total byte count, a direction and optionally a beat size. For a write the host also supplies a wide value. The master cuts the access into beats, drives the pipelined address and data phases, and stores the write value or the read data. It also checks the subordinate's handshake for two kinds of misbehaviour.

Every beat goes out as a NONSEQ transfer, and the address rises by the beat size from one beat to the next. When the host gives no beat size, the master takes it from how far the start address is misaligned to the bus width. Each completed beat is reported as one address/data record, so a host or test can rebuild the address-to-value map. At the end the master drops the bus select for one cycle and then pulses done. A flag is raised for a proper error response, and a separate flag is raised for a handshake that breaks the rules.

Top module: `ahbl_xfer_master`

## Requirements
- R1: While hresetn is low and right after reset, hsel=0, htrans=0 (IDLE), start_ready=1, and done, rec_valid, bus_err and proto_err are all 0.
- R2: The beat size is req_step when req_step is nonzero. When req_step is 0, the beat size is req_addr modulo the bus width in bytes, or the full bus width when that remainder is zero. hsize carries floor(log2(beat size)).
- R3: Beats are issued with htrans=2 (NONSEQ) at addresses req_addr + k*beat size. There are ceil(req_len/beat size) beats, and htrans is 0 (IDLE) after the final address phase. htrans never takes 1 or 3.
- R4: For a write, the data phase of beat k drives the low bus-width bits of req_wdata shifted right by 8*k*beat size bits.
- R5: For a read, the record of each beat carries the hrdata value sampled in the cycle that beat's data phase completes.
- R6: Each completed beat gives exactly one record: rec_valid high for one cycle, with rec_addr set to the beat address and rec_data set to the beat data, in issue order.
- R7: When hreadyout is low with hresp low during the data phase of any beat after the first, the master holds haddr, htrans, hsize and hwdata unchanged.
- R8: hreadyout low in the first data-phase cycle of the first beat sets proto_err and aborts the transfer. No record is produced for that beat.
- R9: hresp=1 with hreadyout=0, followed by hresp=1 with hreadyout=1, sets bus_err and aborts the transfer. The errored beat produces no record.
- R10: hresp=1 with hreadyout=1 in the first error cycle sets proto_err. So does anything other than hresp=1 with hreadyout=1 in the second error cycle. Either case aborts the transfer.
- R11: At the end of every transfer, normal or aborted, hsel and hwrite are 0 for one cycle before done pulses high for one cycle. bus_err and proto_err then hold until the next accepted start, which clears them.
- R12: start is accepted only while start_ready is 1. A start pulse during a transfer has no effect on the beats or records of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host request to begin a transfer |
| start_ready | output | 1 | Master is idle and will accept start |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total bytes to transfer |
| req_step | input | STEP_W | Beat size in bytes; 0 selects automatic |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | VAL_W | Host value for writes |
| hsel | output | 1 | Subordinate select |
| hwrite | output | 1 | Transfer direction |
| haddr | output | ADDR_W | Address phase address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | log2 of beat size |
| hwdata | output | DATA_W | Write data phase value |
| hrdata | input | DATA_W | Read data from subordinate |
| hreadyout | input | 1 | Subordinate ready |
| hresp | input | 1 | Subordinate error response |
| done | output | 1 | One-cycle completion pulse |
| rec_valid | output | 1 | Record strobe |
| rec_addr | output | ADDR_W | Address of completed beat |
| rec_data | output | DATA_W | Data of completed beat |
| bus_err | output | 1 | Proper error response seen |
| proto_err | output | 1 | Subordinate handshake violation seen |

## Verification
The in-module assertions check, on every cycle, that htrans uses only IDLE or NONSEQ and is IDLE whenever hsel is low. They also check that the bus phases stay frozen through a later-beat wait state, that the two error flags are never both set, that done follows a released bus, and that an error's second cycle always ends the transfer. Other behaviour is shown only by the bench's scenarios, which sweep direction, start misalignment, length and wait-state count, and inject each error pattern. These cover the beat-size choice, the exact beat addresses and shifted write data, the count and order of records, read data capture, the choice of flag for each error shape, and that a start during a transfer is ignored.

// File: rtl/ahbl_xfer_master.sv
module ahbl_xfer_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int VAL_W  = 64,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int LEN_W  = $clog2(VAL_W / 8 + 1),
  localparam int STEP_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              hresetn,
  input  logic              start,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [STEP_W-1:0] req_step,
  input  logic              req_write,
  input  logic [VAL_W-1:0]  req_wdata,
  output logic              hsel,
  output logic              hwrite,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hreadyout,
  input  logic              hresp,
  output logic              done,
  output logic              rec_valid,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic              bus_err,
  output logic              proto_err
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [1:0] TR_IDLE = 2'd0;
  localparam logic [1:0] TR_NSEQ = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_ERR2, S_TAIL} st_t;

  st_t               st;
  logic              first;
  logic [STEP_W-1:0] step_r;
  logic [LEN_W-1:0]  len_r;
  logic [VAL_W-1:0]  wdata_r;
  logic [CNT_W-1:0]  sent;
  logic [ADDR_W-1:0] dp_addr;

  function automatic logic [2:0] lg2(input logic [STEP_W-1:0] s);
    lg2 = 3'd0;
    for (int i = 1; i < STEP_W; i++)
      if (s >= (STEP_W'(1) << i)) lg2 = 3'(i);
  endfunction

  logic [OFF_W-1:0]  mis;
  logic [STEP_W-1:0] step_in;
  assign mis     = req_addr[OFF_W-1:0];
  assign step_in = (req_step != '0) ? req_step :
                   (mis == '0) ? STEP_W'(BYTES) : STEP_W'(mis);

  logic [CNT_W-1:0] sent_nx;
  logic [VAL_W-1:0] shifted;
  logic             last_issue;
  assign sent_nx    = sent + CNT_W'(step_r);
  assign last_issue = sent_nx >= CNT_W'(len_r);
  assign shifted    = wdata_r >> {sent, 3'b000};

  logic beat_ok, issue, early_wait, bad_err1, fin, err_bus, err_proto;
  assign beat_ok    = (st == S_DATA) && !hresp && hreadyout;
  assign issue      = (st == S_ADDR) || (beat_ok && htrans == TR_NSEQ);
  assign early_wait = (st == S_DATA) && !hresp && !hreadyout && first;
  assign bad_err1   = (st == S_DATA) && hresp && hreadyout;
  assign err_bus    = (st == S_ERR2) && hresp && hreadyout;
  assign err_proto  = early_wait || bad_err1 || ((st == S_ERR2) && !(hresp && hreadyout));
  assign fin        = early_wait || bad_err1 || (st == S_ERR2) || (beat_ok && htrans != TR_NSEQ);

  assign start_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge hresetn) begin
    if (!hresetn) begin
      st <= S_IDLE; first <= 1'b0;
      step_r <= '0; len_r <= '0; wdata_r <= '0; sent <= '0; dp_addr <= '0;
      hsel <= 1'b0; hwrite <= 1'b0; haddr <= '0; htrans <= TR_IDLE;
      hsize <= 3'd0; hwdata <= '0;
      done <= 1'b0; rec_valid <= 1'b0; rec_addr <= '0; rec_data <= '0;
      bus_err <= 1'b0; proto_err <= 1'b0;
    end else begin
      done      <= 1'b0;
      rec_valid <= 1'b0;
      if (st == S_IDLE && start) begin
        st <= S_ADDR;
        hsel <= 1'b1; hwrite <= req_write; haddr <= req_addr; htrans <= TR_NSEQ;
        hsize <= lg2(step_in);
        step_r <= step_in; len_r <= req_len; wdata_r <= req_wdata; sent <= '0;
        bus_err <= 1'b0; proto_err <= 1'b0;
      end
      if (st == S_ADDR) begin
        st    <= S_DATA;
        first <= 1'b1;
      end
      if (beat_ok) begin
        first     <= 1'b0;
        rec_valid <= 1'b1;
        rec_addr  <= dp_addr;
        rec_data  <= hwrite ? hwdata : hrdata;
      end
      if (issue) begin
        dp_addr <= haddr;
        hwdata  <= shifted[DATA_W-1:0];
        sent    <= sent_nx;
        if (last_issue) htrans <= TR_IDLE;
        else            haddr  <= haddr + ADDR_W'(step_r);
      end
      if (st == S_DATA && hresp && !hreadyout) begin
        st     <= S_ERR2;
        htrans <= TR_IDLE;
      end
      if (err_bus)   bus_err   <= 1'b1;
      if (err_proto) proto_err <= 1'b1;
      if (fin) begin
        st <= S_TAIL; hsel <= 1'b0; hwrite <= 1'b0; htrans <= TR_IDLE;
      end
      if (st == S_TAIL) begin
        st   <= S_IDLE;
        done <= 1'b1;
      end
    end
  end

  p_legal_trans_r3: assert property (@(posedge clk) disable iff (!hresetn)
    htrans != 2'd1 && htrans != 2'd3);

  p_idle_unselected_r3: assert property (@(posedge clk) disable iff (!hresetn)
    !hsel |-> htrans == TR_IDLE);

  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!hresetn)
    (st == S_DATA && !first && !hreadyout && !hresp) |=>
      $stable(haddr) && $stable(htrans) && $stable(hwdata) && $stable(hsize));

  p_err2_ends_r10: assert property (@(posedge clk) disable iff (!hresetn)
    st == S_ERR2 |=> !hsel && (bus_err || proto_err));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!hresetn)
    !(bus_err && proto_err));

  p_done_after_release_r11: assert property (@(posedge clk) disable iff (!hresetn)
    done |-> !hsel && !hwrite && $past(!hsel));

  p_record_in_run_r6: assert property (@(posedge clk) disable iff (!hresetn)
    rec_valid |-> $past(hsel) && !done);
endmodule

// File: tb/ahbl_xfer_master_bench.sv
module ahbl_xfer_master_bench;
  localparam int ADDR_W = 32, DATA_W = 32, VAL_W = 64;
  localparam int BYTES = DATA_W / 8;
  localparam int LEN_W = $clog2(VAL_W / 8 + 1);
  localparam int STEP_W = $clog2(BYTES + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              hresetn, start, start_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [STEP_W-1:0] req_step;
  logic [VAL_W-1:0]  req_wdata;
  logic              hsel, hwrite, hreadyout, hresp, done, rec_valid, bus_err, proto_err;
  logic [ADDR_W-1:0] haddr, rec_addr;
  logic [1:0]        htrans;
  logic [2:0]        hsize;
  logic [DATA_W-1:0] hwdata, hrdata, rec_data;

  ahbl_xfer_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W)) u_ahbl_xfer_master (
    .clk(clk), .hresetn(hresetn), .start(start), .start_ready(start_ready),
    .req_addr(req_addr), .req_len(req_len), .req_step(req_step), .req_write(req_write),
    .req_wdata(req_wdata), .hsel(hsel), .hwrite(hwrite), .haddr(haddr), .htrans(htrans),
    .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
    .done(done), .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
    .bus_err(bus_err), .proto_err(proto_err));

  int vec = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rd_f(input logic [ADDR_W-1:0] a);
    rd_f = {a[7:0] ^ 8'hC3, a[7:0], ~a[7:0], a[7:0] + 8'd1};
  endfunction

  function automatic int flog2(input int s);
    flog2 = 0;
    for (int i = 1; i < 8; i++) if (s >= (1 << i)) flog2 = i;
  endfunction

  // run context
  logic [ADDR_W-1:0] run_a;
  int run_s, run_nb, rk, lowrun;
  logic [VAL_W-1:0] run_v;
  bit run_wr, abort_exp, model_clr;
  int cfg_waits, cfg_err;
  bit cfg_early;

  // subordinate model
  bit pend, pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  int pend_k, wcnt;

  always_comb begin
    hresp = 1'b0;
    hreadyout = 1'b1;
    if (pend) begin
      if (cfg_err != 0 && pend_k == 1) begin
        hresp = 1'b1;
        hreadyout = (wcnt == 0) ? (cfg_err == 2) : (cfg_err == 1);
      end else if (pend_k == 0) hreadyout = !cfg_early;
      else hreadyout = (wcnt >= cfg_waits);
    end
  end
  assign hrdata = pend ? rd_f(pend_addr) : '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (model_clr) begin
      pend <= 1'b0; wcnt <= 0;
    end else if ((!pend || hreadyout) && hsel && htrans == 2'd2) begin
      pend <= 1'b1; pend_addr <= haddr; pend_wr <= hwrite; wcnt <= 0;
      pend_k <= int'(haddr - run_a) / run_s;
    end else if (pend && hreadyout) pend <= 1'b0;
    else if (pend) wcnt <= wcnt + 1;
  end

  // monitors
  bit was_wait;
  logic [ADDR_W-1:0] h_a;
  logic [DATA_W-1:0] h_d;
  always @(negedge clk) begin
    if (hresetn && !model_clr) begin
      if (was_wait) begin
        chk(haddr == h_a, "R7 haddr held in wait", haddr, h_a);
        chk(hwdata == h_d, "R7 hwdata held in wait", hwdata, h_d);
      end
      if (pend && hreadyout && !hresp && pend_wr && !abort_exp) begin
        logic [VAL_W-1:0] sh;
        sh = run_v >> (8 * pend_k * run_s);
        chk(hwdata == sh[DATA_W-1:0], "R4 write data phase", hwdata, sh[DATA_W-1:0]);
      end
      if (hsel && htrans == 2'd2) begin
        int d;
        d = int'(haddr - run_a);
        chk(hsize == 3'(flog2(run_s)), "R2 hsize", hsize, 3'(flog2(run_s)));
        chk(d % run_s == 0 && d / run_s < run_nb, "R3 beat address", haddr, run_a);
      end
      if (rec_valid) begin
        logic [ADDR_W-1:0] ea;
        logic [VAL_W-1:0] sh;
        ea = run_a + ADDR_W'(rk * run_s);
        sh = run_v >> (8 * rk * run_s);
        chk(rec_addr == ea, "R6 record address", rec_addr, ea);
        if (run_wr) chk(rec_data == sh[DATA_W-1:0], "R6 write record data", rec_data, sh[DATA_W-1:0]);
        else        chk(rec_data == rd_f(ea), "R5 read record data", rec_data, rd_f(ea));
        rk++;
      end
    end
    was_wait = pend && !hreadyout && !hresp && pend_k != 0;
    h_a = haddr;
    h_d = hwdata;
    lowrun = hsel ? 0 : lowrun + 1;
  end

  task automatic run(input logic [ADDR_W-1:0] a, input int len, input int step, input bit wr,
                     input logic [VAL_W-1:0] v, input int waits, input bit early, input int err,
                     input bit poke);
    int s, exp_rec, t;
    bit exp_bus, exp_proto;
    @(negedge clk); #1;
    model_clr = 1'b1;
    @(negedge clk); #1;
    model_clr = 1'b0;
    s = (step != 0) ? step : ((a % BYTES) == 0 ? BYTES : int'(a % BYTES));
    run_a = a; run_s = s; run_nb = (len + s - 1) / s; run_v = v; run_wr = wr; rk = 0;
    cfg_waits = waits; cfg_early = early; cfg_err = err;
    abort_exp = early || (err != 0);
    exp_rec = early ? 0 : (err != 0 ? 1 : run_nb);
    exp_bus = (err == 1);
    exp_proto = early || err == 2 || err == 3;
    chk(start_ready == 1'b1, "R12 ready before start", start_ready, 1);
    req_addr = a; req_len = LEN_W'(len); req_step = STEP_W'(step); req_write = wr; req_wdata = v;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    req_addr = 32'hDEAD_0001; req_len = '1; req_step = 3'd1; req_write = !wr; req_wdata = ~v;
    t = 0;
    while (!done && t < 400) begin
      @(negedge clk); #1;
      t++;
      if (poke && t == 2) begin
        chk(start_ready == 1'b0, "R12 busy not ready", start_ready, 0);
        start = 1'b1;
      end else start = 1'b0;
    end
    chk(done == 1'b1, "R11 done reached", done, 1);
    chk(rk == exp_rec, "R6 record count", rk, exp_rec);
    chk(bus_err == exp_bus, "R9 bus_err", bus_err, exp_bus);
    chk(proto_err == exp_proto, "R10 proto_err", proto_err, exp_proto);
    chk(lowrun >= 2 && !hwrite, "R11 select dropped before done", lowrun, 2);
    @(negedge clk); #1;
    chk(done == 1'b0, "R11 done is one pulse", done, 0);
    chk(bus_err == exp_bus && proto_err == exp_proto, "R11 flags held",
        {bus_err, proto_err}, {exp_bus, exp_proto});
  endtask

  initial begin
    hresetn = 1'b0; start = 1'b0; model_clr = 1'b1;
    req_addr = '0; req_len = '0; req_step = '0; req_write = 1'b0; req_wdata = '0;
    run_a = '0; run_s = 4; run_nb = 1; run_v = '0; run_wr = 1'b0; rk = 0;
    cfg_waits = 0; cfg_early = 1'b0; cfg_err = 0; abort_exp = 1'b0;
    repeat (3) @(negedge clk);
    chk(hsel == 1'b0 && htrans == 2'd0, "R1 bus idle in reset", {hsel, htrans}, 0);
    chk(start_ready && !done && !rec_valid && !bus_err && !proto_err, "R1 status in reset",
        {start_ready, done, rec_valid, bus_err, proto_err}, 5'b10000);
    #1 hresetn = 1'b1;
    @(negedge clk);
    chk(hsel == 1'b0 && start_ready == 1'b1, "R1 idle after reset", {hsel, start_ready}, 2'b01);

    for (int wr = 0; wr < 2; wr++)
      for (int off = 0; off < 4; off++)
        for (int len = 1; len <= 8; len++)
          run(32'h200 + 32'(off), len, 0, wr[0],
              64'h0123_4567_89AB_CDEF ^ (64'(len) * 64'h1111_0000_0101_0011),
              (len + off) % 3, 1'b0, 0, 1'b0);

    for (int st = 1; st <= 4; st = st * 2)
      for (int wr = 0; wr < 2; wr++)
        run(32'h301, 8, st, wr[0], 64'hFEDC_BA98_7654_3210, 1, 1'b0, 0, 1'b0);

    run(32'h400, 8, 0, 1'b1, 64'h1122_3344_5566_7788, 0, 1'b0, 1, 1'b0); // R9
    run(32'h400, 8, 0, 1'b1, 64'h1122_3344_5566_7788, 0, 1'b0, 2, 1'b0); // R10
    run(32'h400, 8, 0, 1'b0, 64'h0, 0, 1'b0, 3, 1'b0);                  // R10
    run(32'h500, 8, 2, 1'b0, 64'h0, 0, 1'b1, 0, 1'b0);                  // R8
    run(32'h602, 8, 0, 1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 2, 1'b0, 0, 1'b1); // R12

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    vec++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule